// File: doc/BRIEF.md
# I2C Bus Control Register with Start/Stop Detection

This block is the 8-bit control register of an I2C controller. It watches the SDA and SCL lines through a synchroniser and detects start conditions (SDA falls while SCL is high) and stop conditions (SDA rises while SCL is high). From these it keeps a bus-busy flag that follows the bus itself rather than software writes.

Software writes to the register become command pulses for the master engine. A write with the busy bit at 1 and the issue-disable bit at 0 asks for a start condition. If the bus is already held, that start is a repeated start. A write with both bits at 0 asks for a stop. The register also stores an SDA drive value, which can only be written through a protect bit, and a control-logic reset bit. It shows the synchronised SCL level on a read-only bit.

A format-select input masks the busy flag when the clocked synchronous serial format is in use. The shifter, arbitration and acknowledge handling sit outside this block.

Two state machines do the work. The bus tracker has the states BUS_FREE and BUS_HELD:
- BUS_FREE moves to BUS_HELD on a start.
- BUS_HELD moves to BUS_FREE on a stop.
- BUS_HELD stays in BUS_HELD on a repeated start.
- Both states go to BUS_FREE while the control reset is set.

The request sequencer has the states REQ_IDLE, REQ_START and REQ_STOP:
- Any state moves to REQ_START on an accepted start command.
- Any state moves to REQ_STOP on an accepted stop command.
- With no accepted command, any state returns to REQ_IDLE.
- The control reset forces REQ_IDLE.

Top module: `i2c_ctl_reg`

## Requirements
- R1: After reset `rd_data` reads 0x7D. Bits 6, 2 and 0 always read 1.
- R2: Field positions:
  - bit 7: busy flag
  - bit 6: issue-disable
  - bit 5: SDA drive value
  - bit 4: SDA write protect
  - bit 3: SCL monitor
  - bit 1: control reset
  - bits 2 and 0: reserved

  Writes to bits 3, 2 and 0 have no effect.
- R3: A start condition sets the busy flag. A start is SDA going 1→0 while synchronised SCL is 1 in both the previous and the current sample. The flag is visible after the third rising edge following the input change.
- R4: A stop condition clears the busy flag, with the same timing as R3. A stop is SDA going 0→1 while SCL is 1 in both samples.
- R5: SDA changes while SCL is low do not change the busy flag.
- R6: When `master_sel`=1, a write with bit7=1, bit6=0 and bit1=0 drives `start_req` high for exactly the cycle after the write edge. This also works while the bus is busy (repeated start).
- R7: When `master_sel`=1, a write with bit7=0, bit6=0 and bit1=0 drives `stop_req` high for exactly the cycle after the write edge.
- R8: No request pulse is produced by a write with bit6=1, or by any write while `master_sel`=0. Such a write does not change the busy flag.
- R9: While `fmt_sync`=1, bit 7 reads 0. Bus tracking continues underneath.
- R10: Bit 3 shows the SCL input two rising edges after it changes.
- R11: Bit 5 takes the written value only when the same write has bit4=0. Bit 4 always reads 1. `sda_drive` equals the stored bit 5.
- R12: Bit 1 is stored. While it is 1:
  - the busy flag is held clear;
  - detection restarts from the current sample;
  - no request pulses are produced.

  A write that sets bit 1 produces no pulse itself. Bit 5 is unaffected by bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read value |
| sda_in | input | 1 | SDA line level (asynchronous) |
| scl_in | input | 1 | SCL line level (asynchronous) |
| fmt_sync | input | 1 | 1 = clocked synchronous serial format, 0 = I2C |
| master_sel | input | 1 | 1 = master mode, so commands are accepted |
| start_req | output | 1 | One-cycle start / repeated-start request |
| stop_req | output | 1 | One-cycle stop request |
| sda_drive | output | 1 | Stored SDA drive value |

## Verification
The detector is driven with four bus patterns, each of which separates one behaviour:
- A clean start followed by a stop, which shows that the flag both sets and clears.
- SDA toggling while SCL is low, which shows that data transitions are ignored.
- SDA and SCL moving on the same edge, which shows that SCL must be high in both samples.
- A second start while the bus is held, which exercises the repeated-start path.

Command writes are applied in several ways, which separates the issue-disable gate, the mode gate and the control-reset gate from the command decode:
- start, stop and disabled writes in master mode;
- the same writes in slave mode;
- writes made under control reset.

A behavioural model predicts every output on every cycle.

// File: rtl/i2cctl_pkg.sv
package i2cctl_pkg;
    localparam int REG_W = 8;
    localparam logic [REG_W-1:0] REG_RESET = 8'h7D;

    localparam int F_BUSY  = 7;
    localparam int F_NOISS = 6;
    localparam int F_SDAV  = 5;
    localparam int F_SDAP  = 4;
    localparam int F_SCLM  = 3;
    localparam int F_RSVH  = 2;
    localparam int F_CRST  = 1;
    localparam int F_RSVL  = 0;

    typedef enum logic {
        BUS_FREE,
        BUS_HELD
    } bus_state_e;

    typedef enum logic [1:0] {
        REQ_IDLE,
        REQ_START,
        REQ_STOP
    } req_state_e;
endpackage

// File: rtl/line_sync.sv
module line_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[g] <= '1;
                else        stg[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[g] <= '1;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/cond_detect.sv
module cond_detect
    import i2cctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic sda_s,
    input  logic scl_s,
    output logic busy,
    output logic start_det,
    output logic stop_det
);
    logic       sda_prev, scl_prev;
    bus_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_prev <= 1'b1;
            scl_prev <= 1'b1;
        end else begin
            sda_prev <= sda_s;
            scl_prev <= scl_s;
        end
    end

    always_comb begin
        start_det = scl_s && scl_prev && sda_prev && !sda_s;
        stop_det  = scl_s && scl_prev && !sda_prev && sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_FREE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (clr) begin
            state_d = BUS_FREE;
        end else begin
            unique case (state_q)
                BUS_FREE: if (start_det) state_d = BUS_HELD;
                BUS_HELD: if (stop_det)  state_d = BUS_FREE;
                default:                 state_d = BUS_FREE;
            endcase
        end
    end

    always_comb begin
        busy = (state_q == BUS_HELD);
    end

    // R3
    busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !clr) |=> busy);
    // R4
    busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !clr) |=> !busy);
    // R5
    low_scl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_s && !clr) |=> $stable(busy));
    // R12
    clr_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !busy);
endmodule

// File: rtl/req_gen.sv
module req_gen
    import i2cctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic cmd_start,
    input  logic cmd_stop,
    output logic start_req,
    output logic stop_req
);
    req_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= REQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = REQ_IDLE;
        if (!clr) begin
            unique case (state_q)
                REQ_IDLE, REQ_START, REQ_STOP: begin
                    if (cmd_start)     state_d = REQ_START;
                    else if (cmd_stop) state_d = REQ_STOP;
                    else               state_d = REQ_IDLE;
                end
                default: state_d = REQ_IDLE;
            endcase
        end
    end

    always_comb begin
        start_req = (state_q == REQ_START);
        stop_req  = (state_q == REQ_STOP);
    end

    // R6
    req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_req && stop_req));
    // R6
    start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_req |-> $past(cmd_start));
    // R7
    stop_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |-> $past(cmd_stop));
endmodule

// File: rtl/i2c_ctl_reg.sv
module i2c_ctl_reg
    import i2cctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             sda_in,
    input  logic             scl_in,
    input  logic             fmt_sync,
    input  logic             master_sel,
    output logic             start_req,
    output logic             stop_req,
    output logic             sda_drive
);
    logic [1:0] line_s;
    logic       sda_s, scl_s;
    logic       sdav_q, crst_q;
    logic       busy, start_det, stop_det;
    logic       cmd_ok, cmd_start, cmd_stop;

    line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q(line_s)
    );
    assign sda_s = line_s[0];
    assign scl_s = line_s[1];

    cond_detect u_det (
        .clk(clk), .rst_n(rst_n), .clr(crst_q),
        .sda_s(sda_s), .scl_s(scl_s),
        .busy(busy), .start_det(start_det), .stop_det(stop_det)
    );

    always_comb begin
        cmd_ok    = wr_en && master_sel && !wr_data[F_NOISS]
                    && !wr_data[F_CRST] && !crst_q;
        cmd_start = cmd_ok && wr_data[F_BUSY];
        cmd_stop  = cmd_ok && !wr_data[F_BUSY];
    end

    req_gen u_req (
        .clk(clk), .rst_n(rst_n), .clr(crst_q),
        .cmd_start(cmd_start), .cmd_stop(cmd_stop),
        .start_req(start_req), .stop_req(stop_req)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sdav_q <= REG_RESET[F_SDAV];
            crst_q <= REG_RESET[F_CRST];
        end else if (wr_en) begin
            crst_q <= wr_data[F_CRST];
            if (!wr_data[F_SDAP]) sdav_q <= wr_data[F_SDAV];
        end
    end

    always_comb begin
        rd_data          = '0;
        rd_data[F_BUSY]  = busy && !fmt_sync;
        rd_data[F_NOISS] = 1'b1;
        rd_data[F_SDAV]  = sdav_q;
        rd_data[F_SDAP]  = 1'b1;
        rd_data[F_SCLM]  = scl_s;
        rd_data[F_RSVH]  = 1'b1;
        rd_data[F_CRST]  = crst_q;
        rd_data[F_RSVL]  = 1'b1;
        sda_drive        = sdav_q;
    end

    // R9
    fmt_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_sync |-> !rd_data[F_BUSY]);
    // R11
    sda_protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[F_SDAP]) |=> $stable(sda_drive));
    // R2
    reserved_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[F_RSVH] && !wr_data[F_RSVL] && !wr_data[F_SCLM])
        |=> (rd_data[F_RSVH] && rd_data[F_RSVL]));
    // R8
    disabled_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_data[F_NOISS] || !master_sel)) |=> !(start_req || stop_req));
endmodule

// File: tb/i2c_ctl_reg_bench.sv
`timescale 1ns/1ps
module i2c_ctl_reg_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       sda_in = 1'b1, scl_in = 1'b1;
    logic       fmt_sync = 1'b0, master_sel = 1'b1;
    logic       start_req, stop_req, sda_drive;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    i2c_ctl_reg u_i2c_ctl_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .sda_in(sda_in), .scl_in(scl_in),
        .fmt_sync(fmt_sync), .master_sel(master_sel),
        .start_req(start_req), .stop_req(stop_req), .sda_drive(sda_drive)
    );

    // Behavioural reference model
    bit sda_pipe[$];
    bit scl_pipe[$];
    bit m_sda_prev, m_scl_prev, m_busy, m_sdav, m_crst, m_start, m_stop;

    function automatic bit cur_sda(); return sda_pipe[sda_pipe.size()-1]; endfunction
    function automatic bit cur_scl(); return scl_pipe[scl_pipe.size()-1]; endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            sda_pipe = '{1'b1, 1'b1};
            scl_pipe = '{1'b1, 1'b1};
            m_sda_prev = 1; m_scl_prev = 1; m_busy = 0;
            m_sdav = 1; m_crst = 0; m_start = 0; m_stop = 0;
        end else begin
            bit cs, cl, go;
            cs = sda_pipe[0];
            cl = scl_pipe[0];
            if (m_crst) m_busy = 0;
            else if (cl && m_scl_prev && m_sda_prev && !cs) m_busy = 1;
            else if (cl && m_scl_prev && !m_sda_prev && cs) m_busy = 0;
            m_sda_prev = cs;
            m_scl_prev = cl;
            void'(sda_pipe.pop_front()); sda_pipe.push_back(sda_in);
            void'(scl_pipe.pop_front()); scl_pipe.push_back(scl_in);
            go = wr_en && master_sel && !wr_data[6] && !wr_data[1] && !m_crst;
            m_start = go && wr_data[7];
            m_stop  = go && !wr_data[7];
            if (wr_en) begin
                m_crst = wr_data[1];
                if (!wr_data[4]) m_sdav = wr_data[5];
            end
        end
    end

    function automatic logic [7:0] model_rd();
        return {m_busy && !fmt_sync, 1'b1, m_sdav, 1'b1, scl_pipe[0], 1'b1, m_crst, 1'b1};
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Every-cycle comparison at the falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [7:0] e;
            string tag;
            e = model_rd();
            if (rd_data !== e) begin
                if (rd_data[7] !== e[7]) tag = "R3";
                else if (rd_data[3] !== e[3]) tag = "R10";
                else if (rd_data[5] !== e[5]) tag = "R11";
                else if (rd_data[1] !== e[1]) tag = "R12";
                else tag = "R1";
            end else tag = "R2";
            check(tag, rd_data, e);
            check("R6", {7'd0, start_req}, {7'd0, m_start});
            check("R7", {7'd0, stop_req}, {7'd0, m_stop});
            check("R11", {7'd0, sda_drive}, {7'd0, m_sdav});
        end
    end

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic wr(logic [7:0] d);
        wr_en = 1'b1;
        wr_data = d;
        tick();
        wr_en = 1'b0;
        wr_data = 8'h00;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<=100000", cycles);
            finish_run();
        end
    end

    initial begin
        tick(3);
        // R1: reset value seen during reset
        check("R1", rd_data, 8'h7D);
        rst_n = 1'b1;
        tick(2);
        check("R1", rd_data, 8'h7D);

        // R3: start condition, visible after third edge
        sda_in = 1'b0;
        tick(2);
        check("R3", {7'd0, rd_data[7]}, 8'd0);
        tick(1);
        check("R3", {7'd0, rd_data[7]}, 8'd1);

        // R9: format masks busy, tracking continues
        fmt_sync = 1'b1;
        tick(1);
        check("R9", {7'd0, rd_data[7]}, 8'd0);
        fmt_sync = 1'b0;
        tick(1);
        check("R9", {7'd0, rd_data[7]}, 8'd1);

        // R6: repeated start while busy
        wr(8'hBD);
        check("R6", {6'd0, start_req, stop_req}, 8'b10);
        tick(1);
        check("R6", {6'd0, start_req, stop_req}, 8'b00);

        // R5: SDA toggles while SCL low
        scl_in = 1'b0; tick(3);
        // R10: SCL monitor two edges later
        check("R10", {7'd0, rd_data[3]}, 8'd0);
        sda_in = 1'b1; tick(3);
        sda_in = 1'b0; tick(3);
        sda_in = 1'b1; tick(3);
        check("R5", {7'd0, rd_data[7]}, 8'd1);
        // SCL and SDA rising on the same edge: not a stop
        sda_in = 1'b0; tick(3);
        scl_in = 1'b1; sda_in = 1'b1; tick(4);
        check("R5", {7'd0, rd_data[7]}, 8'd1);
        // R4: stop condition
        sda_in = 1'b0; tick(4);
        sda_in = 1'b1; tick(3);
        check("R4", {7'd0, rd_data[7]}, 8'd0);

        // R7: stop request
        wr(8'h3D);
        check("R7", {6'd0, start_req, stop_req}, 8'b01);
        tick(1);
        // R8: issue-disable set and slave mode
        wr(8'hFD);
        check("R8", {6'd0, start_req, stop_req}, 8'b00);
        master_sel = 1'b0;
        wr(8'hBD);
        check("R8", {6'd0, start_req, stop_req}, 8'b00);
        check("R8", {7'd0, rd_data[7]}, 8'd0);
        master_sel = 1'b1;
        wr(8'hBD);
        check("R6", {6'd0, start_req, stop_req}, 8'b10);

        // R11: protect gates SDA value
        wr(8'h5D);
        check("R11", {7'd0, sda_drive}, 8'd1);
        wr(8'h4D);
        check("R11", {7'd0, sda_drive}, 8'd0);
        check("R11", {7'd0, rd_data[4]}, 8'd1);

        // R12: control reset clears busy, blocks requests, keeps SDA value
        sda_in = 1'b0; tick(4);
        check("R12", {7'd0, rd_data[7]}, 8'd1);
        wr(8'hCF);
        check("R12", {6'd0, start_req, stop_req}, 8'b00);
        tick(1);
        check("R12", {7'd0, rd_data[7]}, 8'd0);
        wr(8'h8F);
        check("R12", {6'd0, start_req, stop_req}, 8'b00);
        check("R12", {7'd0, sda_drive}, 8'd0);
        wr(8'h4D);
        tick(2);
        check("R12", {7'd0, rd_data[7]}, 8'd0);
        sda_in = 1'b1; tick(4);
        sda_in = 1'b0; tick(3);
        check("R3", {7'd0, rd_data[7]}, 8'd1);

        // R2: writes to read-only bits do nothing
        wr(8'h40);
        check("R2", rd_data & 8'h0D, 8'h0D);
        tick(2);
        finish_run();
    end
endmodule